// File: doc/BRIEF.md
# APB Register Bank Completer

This block sits on an APB bus as a completer and holds a parameterised number of 32-bit registers at word-aligned byte addresses (register i lives at byte address 4*i). Writes are merged one byte lane at a time under the write strobes. Reads return the stored word. Each transfer is stretched by a configurable number of wait states before ready rises.

Every completed transfer is checked before it takes effect. An address whose two low bits are not zero is refused. A word index at or beyond the register count is refused. An access that has the non-secure protection bit set and targets a register in the parameterised secure-only set is also refused. A refused transfer ends with the error flag raised and leaves the register contents unchanged. Both the read data and the error flag read zero outside the completion cycle.

Top module: `apb_regbank`

## Requirements
- R1: On active-low reset every register reads back as zero, and pready_o, pslverr_o and prdata_o are all zero.
- R2: pready_o is low in the setup cycle (psel_i=1, penable_i=0) and in the first WAIT_CYCLES access cycles (psel_i=1, penable_i=1). It rises in access cycle number WAIT_CYCLES, counting from 0.
- R3: In a write that completes without error, pstrb_i bit n replaces bits [8n+7:8n] of the register with the same bits of pwdata_i. Byte lanes whose strobe bit is 0 keep their old value. A strobe of 4'b1111 writes the whole word and 4'b0001 writes only the lowest byte.
- R4: In the completion cycle of a read without error (psel_i, penable_i and pready_o all high, pwrite_i=0), prdata_o equals the register's current contents.
- R5: In any cycle that is not a completion cycle, prdata_o is zero and pslverr_o is zero.
- R6: A transfer with paddr_i[1:0] not equal to 0 completes with pslverr_o=1.
- R7: A transfer whose word index paddr_i[ADDR_W-1:2] is NUM_REGS or larger completes with pslverr_o=1.
- R8: A transfer to a register whose SECURE_MASK bit is 1 completes with pslverr_o=1 when pprot_i[1]=1 (non-secure). The same transfer with pprot_i[1]=0 completes normally, whatever the values of pprot_i[0] and pprot_i[2].
- R9: A write that completes with an error leaves every register unchanged. A read that completes with an error returns prdata_o=0.
- R10: No register changes while pready_o is low. A transfer that is dropped before ready rises leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Completer select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | DATA_W | Write data |
| pstrb_i | input | DATA_W/8 | Byte-lane write enables |
| pprot_i | input | 3 | Protection attributes; bit 1 = non-secure |
| prdata_o | output | DATA_W | Read data, non-zero only in a completion cycle |
| pready_o | output | 1 | Transfer completes when high during access |
| pslverr_o | output | 1 | Error response in the completion cycle |

## Verification
Ready, read data and the error flag are combinational on the wait counter, the registers and the bus inputs. They are therefore due in the same cycle as the input phase that produces them. The bench drives inputs on the falling edge and compares all three outputs against a behavioural model one nanosecond later, in every setup and access cycle. The model expects ready in access cycle WAIT_CYCLES. A write becomes visible at the completion edge, so the model updates its register array only after it has checked the completion cycle, and the next read checks the new value.

// File: rtl/apb_regbank_pkg.sv
`timescale 1ns/1ps
package apb_regbank_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_ALIGN = 2'd1,
    CAUSE_MAP   = 2'd2,
    CAUSE_SEC   = 2'd3
  } cause_e;

  localparam int unsigned PROT_NONSEC_BIT = 1;
endpackage

// File: rtl/apb_regbank_decode.sv
`timescale 1ns/1ps
module apb_regbank_decode
  import apb_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 3,
  parameter logic [NUM_REGS-1:0] SECURE_MASK = '0
) (
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              nonsec_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              err_o,
  output cause_e            cause_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              mapped;
  logic              secure_hit;

  assign word   = paddr_i[ADDR_W-1:2];
  assign mapped = (32'(word) < NUM_REGS);
  assign idx_o  = word[IDX_W-1:0];

  always_comb begin
    secure_hit = 1'b0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (32'(word) == i) secure_hit = SECURE_MASK[i];
    end
  end

  // priority: alignment, map, security
  always_comb begin
    if (paddr_i[1:0] != 2'b00)      cause_o = CAUSE_ALIGN;
    else if (!mapped)               cause_o = CAUSE_MAP;
    else if (secure_hit && nonsec_i) cause_o = CAUSE_SEC;
    else                            cause_o = CAUSE_NONE;
  end

  assign err_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/apb_regbank_wait.sv
`timescale 1ns/1ps
module apb_regbank_wait #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  output logic ready_o
);
  generate
    if (WAIT_CYCLES == 0) begin : g_nowait
      assign ready_o = access_i;
    end else begin : g_wait
      localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  cnt_q <= '0;
        else if (!access_i || ready_o) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
      end

      assign ready_o = access_i && (cnt_q == LAST);

      // R2
      cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

      // R2
      wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (access_i && !ready_o) |=> (!access_i || ready_o || cnt_q != '0));
    end
  endgenerate
endmodule

// File: rtl/apb_regbank_regs.sv
`timescale 1ns/1ps
module apb_regbank_regs #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  for (genvar r = 0; r < int'(NUM_REGS); r++) begin : g_reg
    for (genvar b = 0; b < int'(LANES); b++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[r][8*b +: 8] <= 8'h00;
        else if (we_i && (32'(idx_i) == r) && wstrb_i[b])
          mem_q[r][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      if (32'(idx_i) == r) rdata_o = mem_q[r];
    end
  end

  // R10
  hold_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/apb_regbank.sv
`timescale 1ns/1ps
module apb_regbank
  import apb_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned WAIT_CYCLES = 2,
  parameter logic [NUM_REGS-1:0] SECURE_MASK = 8'b0000_1100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  input  logic [DATA_W/8-1:0] pstrb_i,
  input  logic [2:0]          pprot_i,
  output logic [DATA_W-1:0]   prdata_o,
  output logic                pready_o,
  output logic                pslverr_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              access;
  logic              complete;
  logic              dec_err;
  cause_e            dec_cause;
  logic [IDX_W-1:0]  idx;
  logic              reg_we;
  logic [DATA_W-1:0] reg_rdata;
  logic              unused_prot;

  assign unused_prot = pprot_i[0] ^ pprot_i[2];

  assign access   = psel_i && penable_i;
  assign complete = access && pready_o;

  apb_regbank_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SECURE_MASK(SECURE_MASK)
  ) u_decode (
    .paddr_i (paddr_i),
    .nonsec_i(pprot_i[PROT_NONSEC_BIT]),
    .idx_o   (idx),
    .err_o   (dec_err),
    .cause_o (dec_cause)
  );

  apb_regbank_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .access_i(access),
    .ready_o (pready_o)
  );

  assign reg_we = complete && pwrite_i && !dec_err;

  apb_regbank_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .idx_i  (idx),
    .wdata_i(pwdata_i),
    .wstrb_i(pstrb_i),
    .rdata_o(reg_rdata)
  );

  assign prdata_o  = (complete && !pwrite_i && !dec_err) ? reg_rdata : '0;
  assign pslverr_o = complete && dec_err;

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pready_o) |-> (prdata_o == '0 && !pslverr_o));

  // R2
  setup_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !penable_i) |-> !pready_o);

  // R6
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete && paddr_i[1:0] != 2'b00) |-> pslverr_o);

  // R8
  secure_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete && dec_cause == CAUSE_SEC) |-> (pslverr_o && pprot_i[1]));

  // R9
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> !reg_we);

  // R9
  err_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (prdata_o == '0));
endmodule

// File: tb/apb_regbank_tb.sv
`timescale 1ns/1ps
module apb_regbank_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM    = 8;
  localparam int unsigned WAITS  = 2;
  localparam logic [NUM-1:0] SEC = 8'b0000_1100;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [ADDR_W-1:0] paddr_i = '0;
  logic [DATA_W-1:0] pwdata_i = '0;
  logic [3:0]        pstrb_i = '0;
  logic [2:0]        pprot_i = '0;
  logic [DATA_W-1:0] prdata_o;
  logic              pready_o, pslverr_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] model [NUM];

  always #2.5 clk_i = ~clk_i;

  apb_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM),
                .WAIT_CYCLES(WAITS), .SECURE_MASK(SEC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i), .pstrb_i(pstrb_i),
    .pprot_i(pprot_i), .prdata_o(prdata_o), .pready_o(pready_o), .pslverr_o(pslverr_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_err(input logic [7:0] a, input logic [2:0] p);
    int unsigned w = a >> 2;
    if (a[1:0] != 2'b00) return 1'b1;
    if (w >= NUM) return 1'b1;
    if (SEC[w] && p[1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle_check(input string tag);
    check(pready_o == 1'b0, tag, 32'(pready_o), 32'd0);
    check(pslverr_o == 1'b0, tag, 32'(pslverr_o), 32'd0);
    check(prdata_o == '0, tag, prdata_o, 32'd0);
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p, input string tag);
    bit e;
    logic [31:0] m;
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = wr; paddr_i = a;
    pwdata_i = d; pstrb_i = s; pprot_i = p;
    #1 idle_check("R2 setup / R5");
    @(negedge clk_i);
    penable_i = 1'b1;
    for (int k = 0; k <= int'(WAITS); k++) begin
      #1;
      if (k < int'(WAITS)) begin
        idle_check("R2 wait / R5");
        @(negedge clk_i);
      end else begin
        check(pready_o == 1'b1, "R2 ready", 32'(pready_o), 32'd1);
        e = exp_err(a, p);
        check(pslverr_o == e, tag, 32'(pslverr_o), 32'(e));
        if (!wr) begin
          m = (e) ? 32'd0 : model[a >> 2];
          check(prdata_o == m, tag, prdata_o, m);
        end else begin
          check(prdata_o == '0, "R5 write data", prdata_o, 32'd0);
          if (!e)
            for (int b = 0; b < 4; b++)
              if (s[b]) model[a >> 2][8*b +: 8] = d[8*b +: 8];
        end
      end
    end
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0; pwdata_i = '0; pstrb_i = '0;
    #1 idle_check("R5 idle");
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < int'(NUM); i++) model[i] = 32'd0;
    #1 idle_check("R1 in reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 idle_check("R1 after reset");

    for (int i = 0; i < int'(NUM); i++) xfer(1'b0, 8'(4*i), 32'd0, 4'h0, 3'b000, "R1 reset value");

    xfer(1'b1, 8'h00, 32'hA5A5_5A5A, 4'hF, 3'b000, "R3 full word");
    xfer(1'b0, 8'h00, 32'd0, 4'h0, 3'b000, "R4 read back");
    xfer(1'b1, 8'h04, 32'h1122_3344, 4'hF, 3'b000, "R3 full word");
    xfer(1'b1, 8'h04, 32'hAABB_CCDD, 4'b0101, 3'b000, "R3 lanes 0 and 2");
    xfer(1'b0, 8'h04, 32'd0, 4'h0, 3'b000, "R3 merged read");
    xfer(1'b1, 8'h04, 32'hFFFF_FF00, 4'b0001, 3'b000, "R3 lowest byte");
    xfer(1'b1, 8'h04, 32'h7700_0000, 4'b1000, 3'b000, "R3 top byte");
    xfer(1'b0, 8'h04, 32'd0, 4'h0, 3'b000, "R3 merged read");

    xfer(1'b1, 8'h05, 32'hDEAD_BEEF, 4'hF, 3'b000, "R6 misaligned write");
    xfer(1'b1, 8'h06, 32'hDEAD_BEEF, 4'hF, 3'b000, "R6 misaligned write");
    xfer(1'b0, 8'h04, 32'd0, 4'h0, 3'b000, "R9 unchanged after error");
    xfer(1'b0, 8'h07, 32'd0, 4'h0, 3'b000, "R9 misaligned read");

    xfer(1'b1, 8'h20, 32'h1234_5678, 4'hF, 3'b000, "R7 unmapped write");
    xfer(1'b0, 8'hFC, 32'd0, 4'h0, 3'b000, "R7 unmapped read");

    xfer(1'b1, 8'h08, 32'hCAFE_F00D, 4'hF, 3'b010, "R8 nonsecure write");
    xfer(1'b0, 8'h08, 32'd0, 4'h0, 3'b000, "R9 secure reg unchanged");
    xfer(1'b1, 8'h08, 32'hCAFE_F00D, 4'hF, 3'b101, "R8 secure write");
    xfer(1'b0, 8'h08, 32'd0, 4'h0, 3'b000, "R8 secure read");
    xfer(1'b0, 8'h08, 32'd0, 4'h0, 3'b010, "R8 nonsecure read");
    xfer(1'b1, 8'h0C, 32'h0BAD_0BAD, 4'hF, 3'b011, "R8 nonsecure write");
    xfer(1'b1, 8'h10, 32'h5555_AAAA, 4'hF, 3'b010, "R8 open reg nonsecure");
    xfer(1'b0, 8'h0C, 32'd0, 4'h0, 3'b000, "R9 secure reg unchanged");
    xfer(1'b0, 8'h10, 32'd0, 4'h0, 3'b110, "R8 open reg read");

    // R10: write dropped in the first wait cycle
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b1; paddr_i = 8'h04;
    pwdata_i = 32'h0; pstrb_i = 4'hF; pprot_i = 3'b000;
    @(negedge clk_i);
    penable_i = 1'b1;
    #1 check(pready_o == 1'b0, "R10 not ready", 32'(pready_o), 32'd0);
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
    xfer(1'b0, 8'h04, 32'd0, 4'h0, 3'b000, "R10 dropped write unchanged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule